// File: doc/BRIEF.md
# Pipeline Operand Interlock Unit

This unit decides, every cycle, whether the instruction sitting in the second issue stage (I2) of a six-stage in-order pipeline (I1, I2, E1, E2, E3, E4) may move on. It compares the instruction's source registers with the destination registers of older instructions still in the execute stages. Each source carries its own required stage, E1 or E2. When a source cannot yet be forwarded in the stage where it is needed, the unit raises `stall`. The surrounding pipeline then holds I1 and I2 and the unit places a bubble into E1.

The unit keeps a small shadow of the execute stages. Each entry records whether the stage holds a register writer, the destination, and whether the result arrives at E2 (fast) or at E3 (slow). The stall is recomputed from this shadow every cycle, so it drops as soon as the producer reaches a stage that can forward in time. Load-multiple sequences arrive as one micro-operation per cycle, each writing one register. Each micro-operation comes with a count of how many of its sequence remain, including itself, and the unit uses that count to pick the producer class of the micro-operation.

Latency L below means the consumer may enter E1 L cycles after the producer did. The unit therefore inserts max(0, L − distance) bubbles, where distance is how many stages ahead of I2 the producer sits.

Top module: `operand_interlock`

## Requirements
- R1: Out of reset the shadow stages are empty, so the first instruction presented in I2 is never stalled, whatever its sources.
- R2: A slow producer (`i2_kind`=2, load) followed at once by a consumer needing that register at E1 causes exactly two stall cycles. With one unrelated instruction between them it causes one stall cycle, and with two it causes none.
- R3: A slow producer followed at once by a consumer needing the register at E2 causes exactly one stall cycle. With any instruction between them it causes none.
- R4: A fast producer (`i2_kind`=1, result ready at E2) causes one stall cycle to an immediately following E1 consumer. It causes no stall to an E2 consumer, and none once anything separates the two.
- R5: A load-multiple micro-operation (`i2_kind`=3) whose `i2_lm_left` is 1 (the last one) stalls consumers exactly like a single load. Earlier micro-operations with `i2_lm_left` of 3 or more are treated the same way.
- R6: A load-multiple micro-operation with `i2_lm_left`=2 (second-to-last) stalls consumers exactly like a fast producer.
- R7: An instruction with `i2_kind`=0 writes no register and never causes a stall. Register index 0 is compared like any other register.
- R8: `op_wait` bit j is set only for source j when that source is valid and blocked. Sources marked invalid, and sources naming other registers, never stall. `stall` is the OR of the `op_wait` bits.
- R9: While `stall` is high the held instruction is not entered into E1. On the first cycle without stall it enters E1 exactly once, so a consumer right behind it sees it one stage ahead.
- R10: When `i2_valid` is low, `stall` is low and the cycle enters a bubble into E1, whatever the other I2 inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i2_valid | input | 1 | I2 holds an instruction or micro-operation |
| i2_kind | input | 2 | Producer kind: 0 no write, 1 result at E2, 2 load, 3 load-multiple micro-op |
| i2_lm_left | input | CW (4) | Micro-ops of the sequence remaining, this one included (kind 3 only) |
| i2_dst | input | RW (5) | Destination register |
| i2_src_vld | input | NSRC (3) | Per-source valid |
| i2_src_reg | input | NSRC*RW (15) | Source registers, source j at bits j*RW upward |
| i2_src_e1 | input | NSRC (3) | Per-source need stage: 1 needed at E1, 0 needed at E2 |
| stall | output | 1 | Hold I1/I2 and bubble E1 this cycle |
| op_wait | output | NSRC (3) | Per-source blocked flags |

## Verification
The hardest situation to reach from the ports is a slow producer aging through E1 and then E2 while a held consumer watches it. The stall has to stay up for exactly the right number of cycles and then drop, and the released instruction must enter the shadow exactly once. The bench reaches it with a sweep over every producer kind and load-multiple position, both need stages, both match and mismatch, and distances of zero to two unrelated fillers. It holds the consumer and counts stall cycles against a latency computed in the bench. A chained case then places a dependent consumer directly behind a released one, so the released instruction's entry into E1 shows up as a one-cycle stall.

// File: rtl/operand_interlock.sv
module operand_interlock #(
  parameter int RW   = 5,
  parameter int NSRC = 3,
  parameter int CW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i2_valid,
  input  logic [1:0]        i2_kind,
  input  logic [CW-1:0]     i2_lm_left,
  input  logic [RW-1:0]     i2_dst,
  input  logic [NSRC-1:0]   i2_src_vld,
  input  logic [NSRC*RW-1:0] i2_src_reg,
  input  logic [NSRC-1:0]   i2_src_e1,
  output logic              stall,
  output logic [NSRC-1:0]   op_wait
);

  localparam logic [1:0]    K_NONE  = 2'd0;
  localparam logic [1:0]    K_ARITH = 2'd1;
  localparam logic [1:0]    K_LOAD  = 2'd2;
  localparam logic [1:0]    K_LMW   = 2'd3;
  localparam logic [CW-1:0] LM_PEN  = CW'(2);

  logic          in_fast, in_slow, issue;
  logic          e1_fast, e1_slow, e2_slow;
  logic [RW-1:0] e1_dst, e2_dst;

  assign in_fast = (i2_kind == K_ARITH) || (i2_kind == K_LMW && i2_lm_left == LM_PEN);
  assign in_slow = (i2_kind == K_LOAD)  || (i2_kind == K_LMW && i2_lm_left != LM_PEN);
  assign issue   = i2_valid && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e1_fast <= 1'b0;
      e1_slow <= 1'b0;
      e1_dst  <= '0;
      e2_slow <= 1'b0;
      e2_dst  <= '0;
    end else begin
      e1_fast <= issue && in_fast;
      e1_slow <= issue && in_slow;
      e1_dst  <= i2_dst;
      e2_slow <= e1_slow;
      e2_dst  <= e1_dst;
    end
  end

  for (genvar j = 0; j < NSRC; j++) begin : g_src
    logic [RW-1:0] r;
    logic          hit1, hit2;
    assign r    = i2_src_reg[j*RW +: RW];
    assign hit1 = (e1_dst == r) && (e1_slow || (e1_fast && i2_src_e1[j]));
    assign hit2 = (e2_dst == r) && e2_slow && i2_src_e1[j];
    assign op_wait[j] = i2_valid && i2_src_vld[j] && (hit1 || hit2);
  end

  assign stall = |op_wait;

  // R9
  bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !(e1_fast || e1_slow));

  // R9
  issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (i2_valid && !stall && i2_kind != K_NONE) |=> ((e1_fast || e1_slow) && e1_dst == $past(i2_dst)));

  // R2
  stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |=> !stall);

  // R10
  idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !i2_valid |=> !(e1_fast || e1_slow));

  // R7
  empty_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(e1_fast || e1_slow) && !e2_slow) |-> !stall);

endmodule

// File: tb/operand_interlock_tb.sv
module operand_interlock_tb;
  localparam int PERIOD = 10;
  localparam int RW = 5, NSRC = 3, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic i2_valid = 1'b0;
  logic [1:0] i2_kind = '0;
  logic [CW-1:0] i2_lm_left = '0;
  logic [RW-1:0] i2_dst = '0;
  logic [NSRC-1:0] i2_src_vld = '0;
  logic [NSRC*RW-1:0] i2_src_reg = '0;
  logic [NSRC-1:0] i2_src_e1 = '0;
  logic stall;
  logic [NSRC-1:0] op_wait;

  int errors = 0, checks = 0;

  always #(PERIOD/2) clk = ~clk;

  operand_interlock #(.RW(RW), .NSRC(NSRC), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .i2_valid(i2_valid), .i2_kind(i2_kind),
    .i2_lm_left(i2_lm_left), .i2_dst(i2_dst), .i2_src_vld(i2_src_vld),
    .i2_src_reg(i2_src_reg), .i2_src_e1(i2_src_e1), .stall(stall), .op_wait(op_wait));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_instr(input logic v, input logic [1:0] k, input int left, input int dst);
    i2_valid = v; i2_kind = k; i2_lm_left = CW'(left); i2_dst = RW'(dst);
    i2_src_vld = '0; i2_src_reg = '0; i2_src_e1 = '0;
  endtask

  task automatic idle(input int n);
    set_instr(1'b0, 2'd0, 0, 0);
    for (int i = 0; i < n; i++) tick();
  endtask

  // hold the current I2 inputs, count stall cycles, then let it issue
  task automatic count_stalls(output int n);
    n = 0;
    @(negedge clk);
    while (stall && n < 6) begin
      n++;
      tick();
      @(negedge clk);
    end
    tick();
  endtask

  function automatic int latency(input int kind, input int left, input bit need_e1);
    bit fast, slow;
    fast = (kind == 1) || (kind == 3 && left == 2);
    slow = (kind == 2) || (kind == 3 && left != 2);
    if (slow) return need_e1 ? 3 : 2;
    if (fast) return need_e1 ? 2 : 1;
    return 0;
  endfunction

  initial begin
    #(PERIOD*200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, exp, lat;
    string tag;
    tick(); tick();
    @(negedge clk);
    check("R1 stall during reset", int'(stall), 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1: first instruction after reset, all sources valid and E1-needed
    set_instr(1'b1, 2'd1, 0, 3);
    i2_src_vld = 3'b111; i2_src_e1 = 3'b111;
    i2_src_reg = {RW'(0), RW'(0), RW'(0)};
    count_stalls(n);
    check("R1 first instr no stall", n, 0);
    idle(3);

    // Sweep: producer kind / lm position x need stage x distance x match
    for (int pk = 0; pk < 6; pk++) begin
      for (int ne = 0; ne < 2; ne++) begin
        for (int gap = 0; gap < 3; gap++) begin
          for (int m = 0; m < 2; m++) begin
            int kind, left;
            kind = (pk < 3) ? pk : 3;
            left = (pk == 3) ? 1 : (pk == 4) ? 2 : (pk == 5) ? 3 : 0;
            if (kind == 0)      tag = "R7";
            else if (kind == 1) tag = "R4";
            else if (kind == 2) tag = (ne != 0) ? "R2" : "R3";
            else if (left == 2) tag = "R6";
            else                tag = "R5";
            set_instr(1'b1, 2'(kind), left, 5);
            tick();
            for (int g = 0; g < gap; g++) begin
              set_instr(1'b1, 2'd0, 0, 0);
              tick();
            end
            set_instr(1'b1, 2'd1, 0, 9);
            i2_src_vld = 3'b001; i2_src_e1 = {2'b00, ne[0]};
            i2_src_reg = {RW'(0), RW'(0), RW'(m ? 5 : 6)};
            count_stalls(n);
            lat = m ? latency(kind, left, ne[0]) : 0;
            exp = (lat - (gap + 1) > 0) ? lat - (gap + 1) : 0;
            check($sformatf("%s kind=%0d left=%0d e1=%0d gap=%0d match=%0d", tag, kind, left, ne, gap, m), n, exp);
            idle(3);
          end
        end
      end
    end

    // R8: only the matching source waits
    set_instr(1'b1, 2'd2, 0, 7); tick();
    set_instr(1'b1, 2'd1, 0, 9);
    i2_src_vld = 3'b111; i2_src_e1 = 3'b000;
    i2_src_reg = {RW'(9), RW'(7), RW'(1)};
    @(negedge clk);
    check("R8 op_wait pattern", int'(op_wait), 2);
    check("R8 stall is OR", int'(stall), 1);
    count_stalls(n);
    idle(3);

    // R8: invalid source naming the producer's register does not stall
    set_instr(1'b1, 2'd2, 0, 7); tick();
    set_instr(1'b1, 2'd1, 0, 9);
    i2_src_vld = 3'b101; i2_src_e1 = 3'b111;
    i2_src_reg = {RW'(1), RW'(7), RW'(2)};
    count_stalls(n);
    check("R8 invalid source ignored", n, 0);
    idle(3);

    // R7: register 0 compared normally
    set_instr(1'b1, 2'd2, 0, 0); tick();
    set_instr(1'b1, 2'd1, 0, 9);
    i2_src_vld = 3'b100; i2_src_e1 = 3'b000;
    i2_src_reg = {RW'(0), RW'(4), RW'(4)};
    count_stalls(n);
    check("R7 register 0 load to E2 need", n, 1);
    idle(3);

    // R10: invalid I2 with matching source does not stall, and leaves no producer
    set_instr(1'b1, 2'd2, 0, 11); tick();
    set_instr(1'b0, 2'd2, 0, 12);
    i2_src_vld = 3'b001; i2_src_e1 = 3'b001;
    i2_src_reg = {RW'(0), RW'(0), RW'(11)};
    @(negedge clk);
    check("R10 invalid I2 no stall", int'(stall), 0);
    tick();
    set_instr(1'b1, 2'd1, 0, 9);
    i2_src_vld = 3'b001; i2_src_e1 = 3'b001;
    i2_src_reg = {RW'(0), RW'(0), RW'(12)};
    count_stalls(n);
    check("R10 invalid I2 created no producer", n, 0);
    idle(3);

    // R9: released instruction enters E1 exactly once
    set_instr(1'b1, 2'd2, 0, 3); tick();
    set_instr(1'b1, 2'd1, 0, 4);
    i2_src_vld = 3'b001; i2_src_e1 = 3'b001;
    i2_src_reg = {RW'(0), RW'(0), RW'(3)};
    count_stalls(n);
    check("R9 held consumer stall count", n, 2);
    set_instr(1'b1, 2'd1, 0, 8);
    i2_src_vld = 3'b001; i2_src_e1 = 3'b001;
    i2_src_reg = {RW'(0), RW'(0), RW'(4)};
    count_stalls(n);
    check("R9 released instr seen one stage ahead", n, 1);
    idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule